// File: doc/BRIEF.md
# Cascaded Serial Input Scan Controller

This block is the master side of a three-wire digital input bus. A chain of 8-bit parallel-load shift registers, some on the base board and some on plug-in modules, holds the input channels. On a start request the controller asks for the shared clock line and waits for the grant. It then raises a sample strobe, which loads every input into the chain at the same moment. After that it toggles the shift clock once per channel and reads one bit from the serial data line on each toggle. The bits are gathered into a register indexed by channel number, and a one-cycle done pulse is raised at the end.

The clock line is also used by another two-wire bus. The controller therefore keeps a request asserted for the whole scan and drives neither the strobe nor the clock until the grant arrives. The stage count and both clock phase lengths are inputs. They are captured when a scan starts, so software can size the scan to the modules present without the scan being disturbed while it runs.

The state machine has six states:
- IDLE: waits for start.
- REQ: holds the bus request until the grant arrives.
- SAMPLE: drives the strobe for the high-phase length.
- LOW: holds the clock low and captures the data bit on its final cycle.
- HIGH: holds the clock high. The rising edge at its entry advances the chain.
- DONE: a single cycle that pulses done.

The transitions are:
- start: IDLE to REQ.
- granted: REQ to SAMPLE.
- sampled: SAMPLE to LOW.
- bit_taken: LOW to HIGH.
- next_bit: HIGH to LOW.
- last_bit: HIGH to DONE.
- finish: DONE to IDLE.

Top module: `cascade_scan_ctrl`

## Requirements
- R1: After reset the following are low: busy, done, bus request, strobe and shift clock. The channel register reads all zero.
- R2: A start seen in IDLE raises busy and the bus request from the next cycle. Strobe and clock stay low until the grant input is high. Busy stays high through the done cycle.
- R3: Once granted, the strobe is high for exactly the high-phase length. It rises once per scan, before any clock rise, and is never high together with the clock.
- R4: Each scan gives exactly 8 × S clock rises, where S is the latched stage count. A stage input of 0 is treated as 1, and a value above 8 is treated as 8.
- R5: Each clock period is low for the low-phase length and then high for the high-phase length, in system cycles. A programmed length of 0 acts as 1.
- R6: The serial bit is captured on the last low cycle before each clock rise. The k-th bit read, counting from 1, is channel k, stored at bit k−1 of the channel output.
- R7: Channel bits at or above 8 × S read as zero after the scan, even if the chain holds more stages.
- R8: Done is high for one cycle. Busy and the bus request are low on the next cycle. The channel output keeps its value until the next start.
- R9: A start that arrives while busy is ignored and starts no further scan. Changes to the stage count or phase lengths during a scan have no effect on that scan.
- R10: The shift clock is never high unless both the bus request and the grant are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Scan request, one cycle |
| stages_i | input | 4 | Number of 8-bit stages to read (1 to 8) |
| t_low_i | input | 8 | Clock low phase, in system cycles |
| t_high_i | input | 8 | Clock high phase and strobe width, in system cycles |
| bus_req_o | output | 1 | Request for the shared clock line |
| bus_gnt_i | input | 1 | Grant of the shared clock line |
| smp_o | output | 1 | Parallel-load strobe for the chain, active high |
| sclk_o | output | 1 | Shift clock to the chain |
| sdi_i | input | 1 | Serial data from the chain end |
| chan_o | output | 64 | Captured channels, bit k−1 holds channel k |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at scan end |

## Verification
The bench builds the block with its default parameters: 8 stages of 8 bits, so 64 channels, and 8-bit phase counters. This covers both a one-stage scan and a full-length scan, and the clamping of stage values 0 and 15.

Its chain model always holds all 64 bits of data. This shows that bits beyond the active count stay zero. It also shows that bit order follows the clock count rather than the chain contents.

A grant delay of several cycles covers the wait in REQ. Phase values of 0 and 1 cover the shortest clock. A second start with new settings during a scan covers the ignore rule.

// File: rtl/cascade_scan_pkg.sv
package cascade_scan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_SAMPLE,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } scan_state_e;
endpackage

// File: rtl/scan_phase_timer.sv
module scan_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] cnt_q;

    // A zero length is widened to one cycle so every phase makes progress.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= W'(1);
        else if (load)
            cnt_q <= (len == '0) ? W'(1) : len;
        else if (cnt_q > W'(1))
            cnt_q <= cnt_q - W'(1);
    end

    assign last = (cnt_q == W'(1));

    always_ff @(posedge clk) begin
        if (rst_n)
            assert_timer_nonzero_R5: assert (cnt_q != '0)
                else $error("phase counter reached zero");
    end
endmodule

// File: rtl/scan_capture_reg.sv
module scan_capture_reg #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_bit,
    output logic [N-1:0]  bits
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic b_q;
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                b_q <= 1'b0;
            else if (wr_en && (wr_idx == IW'(g)))
                b_q <= wr_bit;
        end
        assign bits[g] = b_q;
    end

    assert_idx_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < N));
endmodule

// File: rtl/cascade_scan_ctrl.sv
module cascade_scan_ctrl
    import cascade_scan_pkg::*;
#(
    parameter int MAX_STAGES = 8,
    parameter int STAGE_BITS = 8,
    parameter int PHASE_W    = 8,
    localparam int MAX_CH    = MAX_STAGES * STAGE_BITS,
    localparam int IDX_W     = $clog2(MAX_CH),
    localparam int SEL_W     = $clog2(MAX_STAGES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [SEL_W-1:0]   stages_i,
    input  logic [PHASE_W-1:0] t_low_i,
    input  logic [PHASE_W-1:0] t_high_i,
    output logic               bus_req_o,
    input  logic               bus_gnt_i,
    output logic               smp_o,
    output logic               sclk_o,
    input  logic               sdi_i,
    output logic [MAX_CH-1:0]  chan_o,
    output logic               busy_o,
    output logic               done_o
);
    scan_state_e state_q, state_d;

    logic [IDX_W-1:0]   idx_q, last_idx_q, last_idx_d;
    logic [PHASE_W-1:0] tlo_q, thi_q, tmr_len;
    logic [SEL_W-1:0]   st_eff;
    logic               tmr_load, tmr_last, accept;

    // Clamp the requested stage count into 1..MAX_STAGES.
    always_comb begin
        if (stages_i == '0)
            st_eff = SEL_W'(1);
        else if (int'(stages_i) > MAX_STAGES)
            st_eff = SEL_W'(MAX_STAGES);
        else
            st_eff = stages_i;
        last_idx_d = IDX_W'(int'(st_eff) * STAGE_BITS - 1);
    end

    assign accept = (state_q == ST_IDLE) && start_i;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)   state_d = ST_REQ;
            ST_REQ:    if (bus_gnt_i) state_d = ST_SAMPLE;
            ST_SAMPLE: if (tmr_last)  state_d = ST_LOW;
            ST_LOW:    if (tmr_last)  state_d = ST_HIGH;
            ST_HIGH:   if (tmr_last)  state_d = (idx_q == last_idx_q) ? ST_DONE : ST_LOW;
            ST_DONE:                  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Scan settings latched at start, bit index advanced after each high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            last_idx_q <= '0;
            tlo_q      <= '0;
            thi_q      <= '0;
        end else if (accept) begin
            idx_q      <= '0;
            last_idx_q <= last_idx_d;
            tlo_q      <= t_low_i;
            thi_q      <= t_high_i;
        end else if ((state_q == ST_HIGH) && tmr_last && (idx_q != last_idx_q)) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    // The timer is reloaded on every entry into a timed state.
    assign tmr_load = (state_d != state_q) &&
                      ((state_d == ST_SAMPLE) || (state_d == ST_LOW) || (state_d == ST_HIGH));
    assign tmr_len  = (state_d == ST_LOW) ? tlo_q : thi_q;

    scan_phase_timer #(.W(PHASE_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .last  (tmr_last)
    );

    scan_capture_reg #(.N(MAX_CH), .IW(IDX_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .wr_en  ((state_q == ST_LOW) && tmr_last),
        .wr_idx (idx_q),
        .wr_bit (sdi_i),
        .bits   (chan_o)
    );

    // Outputs decoded from the state register.
    always_comb begin
        bus_req_o = 1'b0;
        smp_o     = 1'b0;
        sclk_o    = 1'b0;
        busy_o    = 1'b1;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_o = 1'b0;
            ST_REQ:    bus_req_o = 1'b1;
            ST_SAMPLE: begin bus_req_o = 1'b1; smp_o  = 1'b1; end
            ST_LOW:    bus_req_o = 1'b1;
            ST_HIGH:   begin bus_req_o = 1'b1; sclk_o = 1'b1; end
            ST_DONE:   done_o = 1'b1;
            default:   busy_o = 1'b0;
        endcase
    end

    assert_clk_needs_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> (bus_req_o && bus_gnt_i));
    assert_strobe_needs_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_o) |-> bus_gnt_i);
    assert_strobe_clock_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_o && sclk_o));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o && !bus_req_o));
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(last_idx_q) && $stable(tlo_q) && $stable(thi_q)));
    assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(chan_o));
endmodule

// File: tb/cascade_scan_ctrl_tb.sv
module cascade_scan_ctrl_tb;
    localparam int NCH     = 64;
    localparam int GNT_DLY = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [3:0]      stages_i = 4'd1;
    logic [7:0]      t_low_i = 8'd1, t_high_i = 8'd1;
    logic            bus_req_o, bus_gnt_i, smp_o, sclk_o, sdi_i, busy_o, done_o;
    logic [NCH-1:0]  chan_o;

    int errors = 0, checks = 0, done_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cascade_scan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stages_i(stages_i),
        .t_low_i(t_low_i), .t_high_i(t_high_i), .bus_req_o(bus_req_o),
        .bus_gnt_i(bus_gnt_i), .smp_o(smp_o), .sclk_o(sclk_o), .sdi_i(sdi_i),
        .chan_o(chan_o), .busy_o(busy_o), .done_o(done_o)
    );

    // Arbiter model: grants after a delay, holds while requested.
    int gnt_wait = 0;
    logic gnt_q = 1'b0;
    always @(posedge clk) begin
        if (!bus_req_o) begin
            gnt_q    <= 1'b0;
            gnt_wait <= 0;
        end else if (gnt_wait == GNT_DLY) begin
            gnt_q <= 1'b1;
        end else begin
            gnt_wait <= gnt_wait + 1;
        end
    end
    assign bus_gnt_i = gnt_q;

    // Chain model: eight stages, always full; channel 1 sits at the output end.
    logic [NCH-1:0] pins = '0, chain = '0;
    always @(posedge smp_o) chain = pins;
    always @(posedge sclk_o) chain = {1'b0, chain[NCH-1:1]};
    assign sdi_i = chain[0];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Scoreboard queues filled by the driver.
    logic [NCH-1:0] exp_data_q[$];
    int exp_clk_q[$], exp_lo_q[$], exp_hi_q[$];

    // Monitor.
    int rises = 0, hi_cyc = 0, lo_cyc = 0, smp_cyc = 0, smp_rises = 0;
    bit sampled = 1'b0, prev_sclk = 1'b0, prev_smp = 1'b0, prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk_o && !(bus_gnt_i && bus_req_o))
                chk(1'b0, "R10", "clock high without grant", {63'd0, bus_gnt_i}, 64'd1);
            if (smp_o && !bus_gnt_i)
                chk(1'b0, "R2", "strobe before grant", 64'd0, 64'd1);
            if (smp_o && sclk_o)
                chk(1'b0, "R3", "strobe with clock", 64'd1, 64'd0);
            if (prev_done && (done_o || busy_o))
                chk(1'b0, "R8", "done not single or busy held", {62'd0, done_o, busy_o}, 64'd0);
            if (smp_o && !prev_smp) begin
                smp_rises++;
                if (rises != 0) chk(1'b0, "R3", "strobe after clock", 64'(rises), 64'd0);
            end
            if (smp_o) smp_cyc++;
            if (prev_smp && !smp_o) sampled = 1'b1;
            if (sclk_o && !prev_sclk) rises++;
            if (sclk_o) hi_cyc++;
            if (sampled && !sclk_o && !smp_o && !done_o) lo_cyc++;
            if (done_o) begin
                if (exp_data_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 64'd1, 64'd0);
                end else begin
                    logic [NCH-1:0] ed;
                    int ec, el, eh;
                    ed = exp_data_q.pop_front();
                    ec = exp_clk_q.pop_front();
                    el = exp_lo_q.pop_front();
                    eh = exp_hi_q.pop_front();
                    chk(chan_o == ed, "R6/R7", "channel data", chan_o, ed);
                    chk(rises == ec, "R4", "clock rises", 64'(rises), 64'(ec));
                    chk(hi_cyc == ec * eh, "R5", "high cycles", 64'(hi_cyc), 64'(ec * eh));
                    chk(lo_cyc == ec * el, "R5", "low cycles", 64'(lo_cyc), 64'(ec * el));
                    chk(smp_rises == 1 && smp_cyc == eh, "R3", "strobe width",
                        64'(smp_cyc), 64'(eh));
                end
                done_cnt++;
                rises = 0; hi_cyc = 0; lo_cyc = 0; smp_cyc = 0; smp_rises = 0;
                sampled = 1'b0;
            end
        end
        prev_sclk = sclk_o;
        prev_smp  = smp_o;
        prev_done = done_o;
    end

    // Driver: push expectation, launch, optionally disturb, wait for done.
    task automatic run_scan(input int st, input logic [NCH-1:0] data,
                            input int lo, input int hi, input bit disturb);
        int eff, target;
        logic [NCH-1:0] mask;
        eff  = (st == 0) ? 1 : ((st > 8) ? 8 : st);
        mask = (eff == 8) ? '1 : ((64'd1 << (eff * 8)) - 64'd1);
        exp_data_q.push_back(data & mask);
        exp_clk_q.push_back(eff * 8);
        exp_lo_q.push_back((lo == 0) ? 1 : lo);
        exp_hi_q.push_back((hi == 0) ? 1 : hi);
        target   = done_cnt + 1;
        pins     = data;
        stages_i = 4'(st);
        t_low_i  = 8'(lo);
        t_high_i = 8'(hi);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        // R2: busy and request up, strobe still low while grant is pending.
        chk(busy_o && bus_req_o && !smp_o && !sclk_o, "R2", "request phase",
            {60'd0, busy_o, bus_req_o, smp_o, sclk_o}, 64'hC);
        if (disturb) begin
            repeat (12) @(negedge clk);
            stages_i = 4'd8;
            t_low_i  = 8'd5;
            t_high_i = 8'd5;
            start_i  = 1'b1;
            @(negedge clk) start_i = 1'b0;
        end
        while (done_cnt < target) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(chan_o == (data & mask), "R8", "result held after done", chan_o, data & mask);
        chk(!busy_o && !bus_req_o && done_cnt == target, "R9", "no further scan",
            64'(done_cnt), 64'(target));
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run did not finish", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk({busy_o, done_o, bus_req_o, smp_o, sclk_o} == 5'b0, "R1", "idle outputs",
            {59'd0, busy_o, done_o, bus_req_o, smp_o, sclk_o}, 64'd0);
        chk(chan_o == '0, "R1", "channels cleared", chan_o, '0);

        run_scan(1, 64'hF0E1_D2C3_B4A5_9687, 2, 2, 1'b0);   // R4 single stage, R7 upper zero
        run_scan(8, 64'h8000_0000_0000_0001, 1, 1, 1'b0);   // R6 both ends, R4 full
        run_scan(3, 64'hDEAD_BEEF_1234_5678, 0, 0, 1'b0);   // R5 zero phases act as one
        run_scan(0, 64'h0000_0000_0000_00A5, 3, 2, 1'b0);   // R4 zero stages act as one
        run_scan(5, 64'h5A5A_A5A5_0FF0_C33C, 2, 3, 1'b1);   // R9 start and settings ignored
        run_scan(15, 64'h0123_4567_89AB_CDEF, 1, 2, 1'b0);  // R4 clamp to eight
        finish_run();
    end
endmodule